// File: doc/BRIEF.md
# SDRAM Init and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and afterwards supplies the periodic auto-refresh commands. After reset it holds a NOP with clock enable and both data masks high for a programmable number of cycles. It then issues a precharge of both banks, a programmable number of auto-refresh commands (two or more) and a mode register set, and it waits the required NOP gap after each of them. The wait before the first command, the gaps and the refresh interval are all parameters in clock cycles. The integrator converts them from nanoseconds by rounding up.

Once initialization completes, an interval counter records one owed refresh each time the interval expires. While any refresh is owed, the block raises `refresh_req` and waits for `refresh_gnt` from an external arbiter, which guarantees that both banks are idle. The grant causes one auto-refresh command. A one-cycle `refresh_done` pulse marks the first cycle in which the arbiter may place a new command on the pins. Intervals that expire while the block waits for a grant add to a saturating owed count, so those refreshes are still issued later. Read and write traffic, self-refresh and the data path are handled elsewhere.

Top module: `sdram_boot_refresh`

## Requirements
- R1: During and after reset the pins carry NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1), and `sd_cke` and every `sd_dqm` bit stay high at all times. While reset is asserted, `init_done`, `refresh_req` and `refresh_done` are 0.
- R2: After reset is released, the pins show NOP for at least `INIT_WAIT_CYC` cycles (and at most two more) before the first command.
- R3: The initialization order is: one precharge-all (0,0,1,0), then exactly `INIT_REF_COUNT` auto-refresh commands (0,0,0,1), then one mode register set (0,0,0,0). No other command appears before `init_done`.
- R4: Every precharge drives address bit 10 high, which selects both banks.
- R5: The mode register set drives `mode_op` on the address pins with bits 7, 8 and 10 forced to 0, and drives the bank pins to 0.
- R6: During initialization, the next command follows a precharge exactly `T_RP_CYC` cycles later, and follows each auto-refresh exactly `T_RFC_CYC` cycles later.
- R7: `init_done` rises exactly `T_MRD_CYC` cycles after the mode register set cycle, with only NOP in between, and then stays high.
- R8: `refresh_req` first rises exactly `REF_INTERVAL_CYC` cycles after `init_done` rises. It never rises while `init_done` is low.
- R9: `refresh_req` stays high until a grant is sampled with it. A refresh appears on the pins only after a grant, two cycles after the clock edge that samples the grant.
- R10: Every interval that expires while the block waits for a grant is served: after N expirations without a grant (N ≤ 2^DEBT_W−1), exactly N granted refreshes clear `refresh_req`.
- R11: The owed count saturates at 2^DEBT_W−1. Further expirations are not counted.
- R12: `refresh_done` is a one-cycle pulse exactly `T_RFC_CYC` cycles after each granted auto-refresh on the pins. No command follows that refresh earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_op | input | ADDR_W | Operand for the mode register set (reserved bits are cleared) |
| refresh_gnt | input | 1 | Arbiter grant; the banks are idle and the pins are free |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | DQM_W | Data masks, held high |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address / operand pins |
| init_done | output | 1 | High once initialization has completed |
| refresh_req | output | 1 | A refresh is owed and waiting for a grant |
| refresh_done | output | 1 | One-cycle pulse when the refresh recovery time has elapsed |

## Verification
The bench builds the block with a 40-cycle power-up wait, a 3-cycle precharge gap, a 6-cycle refresh gap, a 2-cycle mode gap, an 80-cycle refresh interval and a 3-bit owed count. With these values the complete boot sequence and its exact spacing fit in a few dozen cycles. The short interval lets three intervals pass without a grant, and then ten, so the bench can check both the catch-up behaviour and saturation at seven owed refreshes well inside the run. A mode operand of all ones shows that each reserved bit is cleared.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_REF,
    CMD_MRS
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_POWER,
    ST_PALL,
    ST_PALL_GAP,
    ST_IREF,
    ST_IREF_GAP,
    ST_MRS,
    ST_MRS_GAP,
    ST_RUN,
    ST_REF,
    ST_REF_GAP
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP  = 4'b0111;
  localparam logic [3:0] PIN_PALL = 4'b0010;
  localparam logic [3:0] PIN_REF  = 4'b0001;
  localparam logic [3:0] PIN_MRS  = 4'b0000;

  function automatic logic [3:0] pins_of(input sdr_cmd_e c);
    case (c)
      CMD_PALL: pins_of = PIN_PALL;
      CMD_REF:  pins_of = PIN_REF;
      CMD_MRS:  pins_of = PIN_MRS;
      default:  pins_of = PIN_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= RST_VAL;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdr_refresh_debt.sv
module sdr_refresh_debt #(
  parameter int INTERVAL = 3900,
  parameter int DEBT_W   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic consume,
  output logic owed
);

  localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);
  localparam logic [DEBT_W-1:0] DEBT_MAX = '1;

  logic [IW-1:0]     tick_cnt;
  logic [DEBT_W-1:0] debt;
  logic              tick;

  assign tick = en && (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
    end else if (en) begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt <= '0;
    end else begin
      case ({tick, consume})
        2'b10: if (debt != DEBT_MAX) debt <= debt + 1'b1;
        2'b01: if (debt != '0) debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  assign owed = (debt != '0);

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 1,
  parameter int DQM_W  = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  sdr_cmd_e          cmd,
  input  logic [ADDR_W-1:0] mode_op,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] op_clean;
  logic [ADDR_W-1:0] ap_word;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_op
    if (i == 7 || i == 8 || i == AP_BIT) begin : g_rsv
      assign op_clean[i] = 1'b0;
    end else begin : g_keep
      assign op_clean[i] = mode_op[i];
    end
    assign ap_word[i] = (i == AP_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= PIN_NOP;
      addr <= '0;
      ba   <= '0;
      cke  <= 1'b1;
      dqm  <= '1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= pins_of(cmd);
      ba  <= '0;
      cke <= 1'b1;
      dqm <= '1;
      case (cmd)
        CMD_PALL: addr <= ap_word;
        CMD_MRS:  addr <= op_clean;
        default:  addr <= '0;
      endcase
    end
  end

endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
  import sdr_seq_pkg::*;
#(
  parameter int INIT_WAIT_CYC    = 50000,
  parameter int T_RP_CYC         = 5,
  parameter int T_RFC_CYC        = 18,
  parameter int T_MRD_CYC        = 2,
  parameter int REF_INTERVAL_CYC = 3900,
  parameter int INIT_REF_COUNT   = 2,
  parameter int DEBT_W           = 4,
  parameter int ADDR_W           = 11,
  parameter int BA_W             = 1,
  parameter int DQM_W            = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_op,
  input  logic              refresh_gnt,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              refresh_req,
  output logic              refresh_done
);

  localparam int GAP_MAX = (T_RP_CYC > T_RFC_CYC) ?
                           ((T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC) :
                           ((T_RFC_CYC > T_MRD_CYC) ? T_RFC_CYC : T_MRD_CYC);
  localparam int CNT_MAX = (INIT_WAIT_CYC > GAP_MAX) ? INIT_WAIT_CYC : GAP_MAX;
  localparam int TW      = $clog2(CNT_MAX + 1);
  localparam int IRW     = $clog2(INIT_REF_COUNT + 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(INIT_WAIT_CYC - 1);
  localparam logic [TW-1:0] RP_LOAD   = TW'(T_RP_CYC - 2);
  localparam logic [TW-1:0] RFC_LOAD  = TW'(T_RFC_CYC - 2);
  localparam logic [TW-1:0] MRD_LOAD  = TW'(T_MRD_CYC - 2);

  seq_state_e      st, st_n;
  sdr_cmd_e        cmd_sel;
  logic            tmr_load;
  logic [TW-1:0]   tmr_val;
  logic            tmr_exp;
  logic [IRW-1:0]  ref_left;
  logic            owed;
  logic            take_grant;
  logic            init_q;
  logic            gap_exit_q;
  logic            done_q;

  assign take_grant = (st == ST_RUN) && owed && refresh_gnt;

  always_comb begin
    st_n     = st;
    cmd_sel  = CMD_NOP;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      ST_POWER:    if (tmr_exp) st_n = ST_PALL;
      ST_PALL: begin
        cmd_sel  = CMD_PALL;
        tmr_load = 1'b1;
        tmr_val  = RP_LOAD;
        st_n     = ST_PALL_GAP;
      end
      ST_PALL_GAP: if (tmr_exp) st_n = ST_IREF;
      ST_IREF: begin
        cmd_sel  = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = RFC_LOAD;
        st_n     = ST_IREF_GAP;
      end
      ST_IREF_GAP: if (tmr_exp) st_n = (ref_left == '0) ? ST_MRS : ST_IREF;
      ST_MRS: begin
        cmd_sel  = CMD_MRS;
        tmr_load = 1'b1;
        tmr_val  = MRD_LOAD;
        st_n     = ST_MRS_GAP;
      end
      ST_MRS_GAP:  if (tmr_exp) st_n = ST_RUN;
      ST_RUN:      if (take_grant) st_n = ST_REF;
      ST_REF: begin
        cmd_sel  = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = RFC_LOAD;
        st_n     = ST_REF_GAP;
      end
      ST_REF_GAP:  if (tmr_exp) st_n = ST_RUN;
      default:     st_n = ST_POWER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_POWER;
      ref_left   <= IRW'(INIT_REF_COUNT);
      init_q     <= 1'b0;
      gap_exit_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st <= st_n;
      if (st == ST_IREF) ref_left <= ref_left - 1'b1;
      init_q     <= init_q | (st == ST_RUN);
      gap_exit_q <= (st == ST_REF_GAP) && tmr_exp;
      done_q     <= gap_exit_q;
    end
  end

  sdr_gap_timer #(
    .W       (TW),
    .RST_VAL (WAIT_LOAD)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sdr_refresh_debt #(
    .INTERVAL (REF_INTERVAL_CYC),
    .DEBT_W   (DEBT_W)
  ) u_debt (
    .clk     (clk),
    .rst     (rst),
    .en      (init_q),
    .consume (take_grant),
    .owed    (owed)
  );

  sdr_cmd_drive #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .DQM_W  (DQM_W),
    .AP_BIT (10)
  ) u_drive (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd_sel),
    .mode_op (mode_op),
    .cs_n    (sd_cs_n),
    .ras_n   (sd_ras_n),
    .cas_n   (sd_cas_n),
    .we_n    (sd_we_n),
    .cke     (sd_cke),
    .dqm     (sd_dqm),
    .ba      (sd_ba),
    .addr    (sd_addr)
  );

  assign init_done    = init_q;
  assign refresh_req  = (st == ST_RUN) && owed;
  assign refresh_done = done_q;

endmodule

// File: rtl/sdram_boot_refresh_chk.sv
module sdram_boot_refresh_chk #(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done,
  input logic              refresh_req,
  input logic              refresh_gnt,
  input logic              refresh_done
);

  logic [3:0] pins;
  logic is_nop, is_pall, is_mrs;

  assign pins    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_pall = (pins == 4'b0010);
  assign is_mrs  = (pins == 4'b0000);

  // R4
  pall_a10_chk: assert property (@(posedge clk) disable iff (rst)
    is_pall |-> sd_addr[10]);

  // R5
  mrs_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (!sd_addr[7] && !sd_addr[8] && !sd_addr[10] && (sd_ba == '0)));

  // R7
  mrs_gap_nop_chk: assert property (@(posedge clk) disable iff (rst)
    is_mrs |=> is_nop);

  // R7
  init_hold_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R8
  req_needs_init_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> init_done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && !refresh_gnt) |=> refresh_req);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_done |=> !refresh_done);

endmodule

bind sdram_boot_refresh sdram_boot_refresh_chk #(
  .ADDR_W (ADDR_W),
  .BA_W   (BA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sd_cs_n      (sd_cs_n),
  .sd_ras_n     (sd_ras_n),
  .sd_cas_n     (sd_cas_n),
  .sd_we_n      (sd_we_n),
  .sd_ba        (sd_ba),
  .sd_addr      (sd_addr),
  .init_done    (init_done),
  .refresh_req  (refresh_req),
  .refresh_gnt  (refresh_gnt),
  .refresh_done (refresh_done)
);

// File: tb/sdram_boot_refresh_bench.sv
`timescale 1ns/1ps
module sdram_boot_refresh_bench;

  localparam int INIT_W = 40;
  localparam int TRP    = 3;
  localparam int TRFC   = 6;
  localparam int TMRD   = 2;
  localparam int RINT   = 80;
  localparam int DW     = 3;
  localparam int AW     = 11;
  localparam logic [3:0] P_NOP  = 4'b0111;
  localparam logic [3:0] P_PALL = 4'b0010;
  localparam logic [3:0] P_REF  = 4'b0001;
  localparam logic [3:0] P_MRS  = 4'b0000;

  typedef struct packed {
    logic [3:0]    pins;
    logic          chk_addr;
    logic [AW-1:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] mode_op = '0;
  logic refresh_gnt = 1'b0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
  logic [1:0] sd_dqm;
  logic [0:0] sd_ba;
  logic [AW-1:0] sd_addr;
  logic init_done, refresh_req, refresh_done;

  always #2 clk = ~clk;

  sdram_boot_refresh #(
    .INIT_WAIT_CYC    (INIT_W),
    .T_RP_CYC         (TRP),
    .T_RFC_CYC        (TRFC),
    .T_MRD_CYC        (TMRD),
    .REF_INTERVAL_CYC (RINT),
    .INIT_REF_COUNT   (2),
    .DEBT_W           (DW),
    .ADDR_W           (AW),
    .BA_W             (1),
    .DQM_W            (2)
  ) u_sdram_boot_refresh (
    .clk          (clk),
    .rst          (rst),
    .mode_op      (mode_op),
    .refresh_gnt  (refresh_gnt),
    .sd_cs_n      (sd_cs_n),
    .sd_ras_n     (sd_ras_n),
    .sd_cas_n     (sd_cas_n),
    .sd_we_n      (sd_we_n),
    .sd_cke       (sd_cke),
    .sd_dqm       (sd_dqm),
    .sd_ba        (sd_ba),
    .sd_addr      (sd_addr),
    .init_done    (init_done),
    .refresh_req  (refresh_req),
    .refresh_done (refresh_done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t sb_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] p, input logic ca, input logic [AW-1:0] a);
    exp_t e;
    e.pins = p;
    e.chk_addr = ca;
    e.addr = a;
    sb_q.push_back(e);
  endtask

  // monitor state
  bit seen_cmd = 0;
  bit init_seen = 0;
  bit req_seen = 0;
  bit done_prev = 0;
  bit side_bad = 0;
  int nop_run = 0;
  int last_cyc = 0;
  logic [3:0] last_pins = 4'b0111;
  int mrs_cyc = 0;
  int init_cyc = 0;
  int exp_done = -1;
  int gnt_cyc = 0;

  always @(negedge clk) begin
    logic [3:0] pins;
    exp_t e;
    if (!rst) begin
      pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!sd_cke || sd_dqm != 2'b11) side_bad = 1;
      if (pins == P_NOP) begin
        if (!seen_cmd) nop_run++;
      end else begin
        if (sb_q.size() == 0) begin
          chk(0, "R9", "command with no grant or expectation", pins, P_NOP);
        end else begin
          e = sb_q.pop_front();
          chk(pins == e.pins, init_seen ? "R9" : "R3", "command code", pins, e.pins);
          if (e.chk_addr) begin
            chk(sd_addr == e.addr, "R5", "mode operand on address", sd_addr, e.addr);
            chk(sd_ba == 1'b0, "R5", "bank pins during mode set", sd_ba, 0);
          end
        end
        if (pins == P_PALL) chk(sd_addr[10], "R4", "precharge A10", sd_addr[10], 1);
        if (!seen_cmd) begin
          chk(nop_run >= INIT_W && nop_run <= INIT_W + 2, "R2", "power-up NOP cycles",
              nop_run, INIT_W);
        end else if (!init_seen) begin
          if (last_pins == P_PALL)
            chk(cyc - last_cyc == TRP, "R6", "gap after precharge", cyc - last_cyc, TRP);
          if (last_pins == P_REF)
            chk(cyc - last_cyc == TRFC, "R6", "gap after init refresh", cyc - last_cyc, TRFC);
        end else if (last_pins == P_REF) begin
          chk(cyc - last_cyc >= TRFC, "R12", "gap after refresh", cyc - last_cyc, TRFC);
        end
        if (pins == P_REF && init_seen) begin
          chk(cyc == gnt_cyc + 2, "R9", "refresh cycle after grant", cyc, gnt_cyc + 2);
          exp_done = cyc + TRFC;
        end
        if (pins == P_MRS) mrs_cyc = cyc;
        seen_cmd = 1;
        last_cyc = cyc;
        last_pins = pins;
      end
      if (init_done && !init_seen) begin
        chk(cyc == mrs_cyc + TMRD, "R7", "init_done after mode set", cyc, mrs_cyc + TMRD);
        init_seen = 1;
        init_cyc = cyc;
      end
      if (!init_done && init_seen) chk(0, "R7", "init_done fell", 0, 1);
      if (refresh_req && !req_seen) begin
        chk(init_seen && cyc == init_cyc + RINT, "R8", "first request cycle",
            cyc, init_cyc + RINT);
        req_seen = 1;
      end
      if (refresh_done) begin
        chk(cyc == exp_done, "R12", "done pulse cycle", cyc, exp_done);
        chk(!done_prev, "R12", "done longer than one cycle", 1, 0);
      end
      done_prev = refresh_done;
    end
  end

  task automatic wait_rel(input int n);
    while (cyc < init_cyc + n) @(negedge clk);
  endtask

  task automatic serve(input int expect_n, input string tag);
    int served = 0;
    while (refresh_req && served < 20) begin
      push(P_REF, 1'b0, '0);
      gnt_cyc = cyc;
      refresh_gnt = 1'b1;
      @(negedge clk);
      refresh_gnt = 1'b0;
      for (int k = 0; k < 50 && !refresh_done; k++) @(negedge clk);
      served++;
    end
    chk(served == expect_n, tag, "refreshes served before request cleared", served, expect_n);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog expired: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    mode_op = 11'h7FF;
    push(P_PALL, 1'b0, '0);
    push(P_REF,  1'b0, '0);
    push(P_REF,  1'b0, '0);
    push(P_MRS,  1'b1, 11'h27F);   // R5: bits 7, 8, 10 cleared
    repeat (5) @(negedge clk);
    // R1 reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP, "R1", "pins in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, P_NOP);
    chk(sd_cke == 1'b1 && sd_dqm == 2'b11, "R1", "cke/dqm in reset", {sd_cke, sd_dqm}, 7);
    chk(!init_done && !refresh_req && !refresh_done, "R1", "status in reset",
        {init_done, refresh_req, refresh_done}, 0);
    rst = 1'b0;
    for (int k = 0; k < 1000 && !init_done; k++) @(negedge clk);
    @(negedge clk);
    chk(sb_q.size() == 0, "R3", "init commands outstanding", sb_q.size(), 0);

    // R10: three intervals pass with no grant
    wait_rel(3 * RINT + 5);
    chk(refresh_req, "R9", "request held without grant", refresh_req, 1);
    serve(3, "R10");

    // R11: ten intervals pass with no grant, owed count saturates
    wait_rel(13 * RINT + 5);
    chk(refresh_req, "R9", "request held over many intervals", refresh_req, 1);
    serve(7, "R11");

    repeat (4) @(negedge clk);
    chk(!refresh_req, "R10", "request after catch-up", refresh_req, 0);
    chk(sb_q.size() == 0, "R9", "granted refreshes outstanding", sb_q.size(), 0);
    chk(!side_bad, "R1", "cke/dqm stayed high", side_bad, 0);
    finish_run();
  end

endmodule